// File: doc/BRIEF.md
# One-Hot Opcode Registered ALU

This block is an 8-bit arithmetic and logic unit. It takes two operands and a 16-bit opcode word. Exactly one opcode bit in the low byte picks the operation. The unit offers addition, subtraction, bitwise inversion of the first operand, and five two-operand logic functions. The outcome is stored in an output register on the rising clock edge, so each operation takes one cycle from input to output.

Subtraction gives a magnitude result together with a separate negative flag, which shows that the second operand was larger. An opcode that is not one of the eight legal one-hot values stores zero. A synchronous active-low reset clears the output register.

Top module: `onehot_alu`

## Requirements
- R1: Opcode 0x0001 (bit 0) registers (A + B) mod 256. The carry out is discarded.
- R2: Opcode 0x0002 (bit 1) with A >= B registers A - B and clears the negative flag. This includes A == B, which gives 0.
- R3: Opcode 0x0002 with B > A registers B - A and sets the negative flag to 1.
- R4: Opcode 0x0004 (bit 2) registers the bitwise complement of A. B has no effect on the result.
- R5: Opcode 0x0008 (bit 3) registers NOT(A AND B). Opcode 0x0010 (bit 4) registers NOT(A OR B).
- R6: Opcode 0x0020 (bit 5) registers A AND B. Opcode 0x0040 (bit 6) registers A XOR B. Opcode 0x0080 (bit 7) registers A OR B.
- R7: Every legal opcode other than 0x0002 registers a negative flag of 0.
- R8: Any opcode that is not exactly one of the eight values 0x0001..0x0080 registers result 0 with the negative flag 0. This covers zero, words with two or more bits set, and single bits in positions 8 to 15.
- R9: The outputs change only at a rising clock edge. The values captured there reflect the inputs present just before that edge, and they hold while the inputs change between edges.
- R10: While the reset input is low at a rising edge, the result and the negative flag become 0 at that edge. The reset does not act between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| opcode | input | 16 | One-hot operation select word |
| result | output | 8 | Registered result |
| negFlag | output | 1 | Registered negative flag for subtraction |

## Verification
Illegal opcodes are the hardest case to reach from the ports. These are words with several bits set, or a single bit in the upper byte. Uniform random words rarely land on the legal values and rarely land on the borderline illegal ones, so they give little of either. The stimulus picks the opcode from weighted classes: the eight legal values, zero, a lone upper-byte bit, a two-bit word, and a fully random word. Directed cases cover the subtraction boundary at A == B and at B = A + 1, and also an input change and a reset assertion placed between clock edges.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W  = 8;
  localparam int OPC_W   = 16;
  localparam int NUM_OPS = 8;

  localparam int OP_ADD  = 0;
  localparam int OP_SUB  = 1;
  localparam int OP_INV  = 2;
  localparam int OP_NAND = 3;
  localparam int OP_NOR  = 4;
  localparam int OP_AND  = 5;
  localparam int OP_XOR  = 6;
  localparam int OP_OR   = 7;

  typedef struct packed {
    logic [NUM_OPS-1:0] sel;
    logic               valid;
  } aluCtrl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int OpcW  = OPC_W,
  parameter int NOps  = NUM_OPS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OpcW-1:0] opcode,
  output aluCtrl_t        ctrl
);
  logic [NOps-1:0] selVec;

  for (genvar i = 0; i < NOps; i++) begin : g_sel
    localparam logic [OpcW-1:0] CODE = OpcW'(1) << i;
    assign selVec[i] = (opcode == CODE);
  end

  always_comb begin
    ctrl.sel   = selVec;
    ctrl.valid = |selVec;
  end

  // R8: at most one strobe may be active, and none when the word has a bit outside the low byte
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrl.sel));
  a_r8_upper_kills: assert property (@(posedge clk) disable iff (!rstN)
    (|opcode[OpcW-1:NOps]) |-> !ctrl.valid);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DataW = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtrl_t         ctrl,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  output logic [DataW-1:0] result,
  output logic             negFlag
);
  logic [DataW-1:0] sum;
  logic [DataW-1:0] magnitude;
  logic             bGreater;
  logic [DataW-1:0] nextRes;
  logic             nextNeg;

  assign sum       = opA + opB;
  assign bGreater  = (opB > opA);
  assign magnitude = bGreater ? (opB - opA) : (opA - opB);

  always_comb begin
    nextRes = '0;
    nextNeg = 1'b0;
    if (ctrl.valid) begin
      if (ctrl.sel[OP_ADD])  nextRes = sum;
      if (ctrl.sel[OP_SUB]) begin
        nextRes = magnitude;
        nextNeg = bGreater;
      end
      if (ctrl.sel[OP_INV])  nextRes = ~opA;
      if (ctrl.sel[OP_NAND]) nextRes = ~(opA & opB);
      if (ctrl.sel[OP_NOR])  nextRes = ~(opA | opB);
      if (ctrl.sel[OP_AND])  nextRes = opA & opB;
      if (ctrl.sel[OP_XOR])  nextRes = opA ^ opB;
      if (ctrl.sel[OP_OR])   nextRes = opA | opB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      negFlag <= 1'b0;
    end else begin
      result  <= nextRes;
      negFlag <= nextNeg;
    end
  end

  // R3/R7: a set flag can only follow a subtract strobe with B above A
  a_r7_neg_needs_sub: assert property (@(posedge clk) disable iff (!rstN)
    negFlag |-> $past(ctrl.sel[OP_SUB]) && $past(opB > opA));
  // R8: an empty strobe set stores zero
  a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.valid |=> (result == '0) && !negFlag);
  // R2: a subtract with A not below B never yields a value above A
  a_r2_sub_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.sel[OP_SUB] && !bGreater) |=> (result <= $past(opA)) && !negFlag);
endmodule

// File: rtl/onehot_alu.sv
module onehot_alu
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] result,
  output logic              negFlag
);
  aluCtrl_t ctrl;

  alu_decode #(.OpcW(OPC_W), .NOps(NUM_OPS)) u_decode (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.DataW(DATA_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .negFlag (negFlag)
  );

  // R10: a low reset sampled at an edge leaves both outputs cleared
  a_r10_reset_clears: assert property (@(posedge clk)
    !rstN |=> (result == '0) && !negFlag);
  // R1: the addition opcode stores the truncated sum with no flag
  a_r1_add_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OPC_W'(1)) |=> (result == DATA_W'($past(opA) + $past(opB))) && !negFlag);
endmodule

// File: tb/onehot_alu_bench.sv
module onehot_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  opA, opB;
  logic [15:0] opcode;
  logic [7:0]  result;
  logic        negFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onehot_alu u_onehot_alu (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .opcode(opcode), .result(result), .negFlag(negFlag)
  );

  function automatic logic [8:0] model(logic [7:0] a, logic [7:0] b, logic [15:0] op);
    case (op)
      16'h0001: return {1'b0, 8'(a + b)};
      16'h0002: return (b > a) ? {1'b1, 8'(b - a)} : {1'b0, 8'(a - b)};
      16'h0004: return {1'b0, ~a};
      16'h0008: return {1'b0, ~(a & b)};
      16'h0010: return {1'b0, ~(a | b)};
      16'h0020: return {1'b0, a & b};
      16'h0040: return {1'b0, a ^ b};
      16'h0080: return {1'b0, a | b};
      default:  return 9'd0;
    endcase
  endfunction

  function automatic string tagOf(logic [7:0] a, logic [7:0] b, logic [15:0] op);
    case (op)
      16'h0001: return "R1";
      16'h0002: return (b > a) ? "R3" : "R2";
      16'h0004: return "R4";
      16'h0008, 16'h0010: return "R5";
      16'h0020, 16'h0040, 16'h0080: return "R6";
      default:  return "R8";
    endcase
  endfunction

  task automatic compare(string tag, logic [7:0] expRes, logic expNeg);
    checks++;
    if (result !== expRes || negFlag !== expNeg) begin
      errors++;
      $display("FAIL %s: got result=%h neg=%b expected result=%h neg=%b",
               tag, result, negFlag, expRes, expNeg);
    end
  endtask

  // drive at the falling edge, sample 1 time unit after the capturing rising edge
  task automatic runOp(logic [7:0] a, logic [7:0] b, logic [15:0] op, string tag = "");
    logic [8:0] e;
    @(negedge clk);
    opA = a; opB = b; opcode = op;
    @(posedge clk); #1;
    e = model(a, b, op);
    compare((tag == "") ? tagOf(a, b, op) : tag, e[7:0], e[8]);
  endtask

  function automatic logic [15:0] pickOpcode();
    int cls = $urandom % 12;
    int i, j;
    if (cls < 8) return 16'(1) << cls;
    if (cls == 8) return 16'h0000;
    if (cls == 9) return 16'($urandom);
    if (cls == 10) return 16'(1) << (8 + $urandom % 8);
    i = $urandom % 16;
    j = (i + 1 + $urandom % 15) % 16;
    return (16'(1) << i) | (16'(1) << j);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    void'($urandom(32'd4242));
    rstN = 1'b0; opA = 8'h5A; opB = 8'h33; opcode = 16'h0001;
    repeat (2) @(posedge clk);
    #1 compare("R10", 8'h00, 1'b0);
    @(negedge clk) rstN = 1'b1;

    runOp(8'hF0, 8'h20, 16'h0001);            // R1 wrap: 0x110 -> 0x10
    runOp(8'hFF, 8'h01, 16'h0001);            // R1 wrap to zero
    runOp(8'h40, 8'h40, 16'h0002);            // R2 equal operands
    runOp(8'h80, 8'h01, 16'h0002);            // R2
    runOp(8'h10, 8'h11, 16'h0002);            // R3 boundary B = A + 1
    runOp(8'h00, 8'hFF, 16'h0002);            // R3 extreme
    runOp(8'h3C, 8'hFF, 16'h0004);            // R4
    runOp(8'h3C, 8'h00, 16'h0004);            // R4 B ignored
    runOp(8'hCC, 8'hAA, 16'h0008);            // R5
    runOp(8'hCC, 8'hAA, 16'h0010);            // R5
    runOp(8'hCC, 8'hAA, 16'h0020);            // R6
    runOp(8'hCC, 8'hAA, 16'h0040);            // R6
    runOp(8'hCC, 8'hAA, 16'h0080);            // R6
    runOp(8'h00, 8'h01, 16'h0002);            // sets flag
    runOp(8'h00, 8'h01, 16'h0080, "R7");      // flag must drop on OR
    runOp(8'h12, 8'h34, 16'h0000);            // R8 zero
    runOp(8'h12, 8'h34, 16'h0003);            // R8 two bits
    runOp(8'h12, 8'h34, 16'h0100);            // R8 upper bit
    runOp(8'h12, 8'h34, 16'h8001);            // R8 legal bit plus upper bit

    // R9: inputs change between edges; outputs must hold until the next edge
    runOp(8'h05, 8'h03, 16'h0001, "R9");
    @(negedge clk);
    opA = 8'hA0; opB = 8'h0B; opcode = 16'h0040;
    #1 compare("R9", 8'h08, 1'b0);
    @(posedge clk); #1 compare("R9", 8'hAB, 1'b0);

    // R10: reset low between edges has no effect until an edge samples it
    runOp(8'h01, 8'h09, 16'h0002);
    @(negedge clk) rstN = 1'b0;
    #1 compare("R10", 8'h08, 1'b1);
    @(posedge clk); #1 compare("R10", 8'h00, 1'b0);
    @(negedge clk) rstN = 1'b1;

    for (int k = 0; k < 400; k++) begin
      logic [15:0] op = pickOpcode();
      logic [7:0]  a  = 8'($urandom);
      logic [7:0]  b  = (k % 7 == 0) ? a : 8'($urandom);
      runOp(a, b, op);
      if (op != 16'h0002 && negFlag !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R7: got neg=%b expected neg=0", negFlag);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule